// File: doc/BRIEF.md
# Dataflow Issue Queue with Oldest-First Select

This block holds renamed instructions until the physical registers they read have been produced. Each slot keeps two source register tags, each with a ready flag, a destination register tag and a program-order age. Values are not stored here. A slot only tracks whether its sources exist. Up to three result buses report finished destination tags in each cycle. Every slot compares both of its source tags against all of them at once, and sets the ready flag of each source that matches.

A slot whose two sources are both ready requests issue. In any cycle the selector picks the oldest requester. Its tags go out to the register-file read stage in that same cycle, and the slot is freed at the next clock edge. A branch misprediction is handled with a flush that carries an age bound. Every slot younger than the bound is dropped. Insertion is refused while every slot is occupied.

Ages come from a wrapping sequence counter of `AGE_W` bits. The block assumes that all live ages and any flush bound lie within half the counter range of each other.

Top module: `iq_dataflow`

## Requirements
- R1: After a synchronous reset the queue is empty: `ins_ready` is 1 and `iss_valid` is 0.
- R2: When `ins_valid` and `ins_ready` are both 1 and `flush_valid` is 0, the instruction is written into a free slot. `ins_ready` is 0 whenever all `DEPTH` (16) slots are occupied, and an insertion offered then is dropped: it never issues.
- R3: A source whose tag equals `wb_tag[k]` while `wb_valid[k]` is 1, on any bus k of the three, becomes ready at the next edge. It stays ready until its slot leaves the queue.
- R4: A result tag broadcast in the same cycle that an instruction is inserted marks the matching source of the new slot ready.
- R5: A slot requests issue only when both of its sources are ready. A slot with one pending source is never issued.
- R6: Among the requesters, the slot with the oldest age is granted. Age a is older than age b when bit `AGE_W-1` of (a - b) mod 2^`AGE_W` is 1, so the ordering survives counter wrap.
- R7: At most one slot is granted per cycle. In the grant cycle, `iss_valid` is 1 and the granted slot's source tags, destination tag and age are on the `iss_*` outputs. The slot is freed at that cycle's edge and is never issued twice.
- R8: While `flush_valid` is 1, every slot whose age is younger than `flush_age` (by the R6 ordering) is removed at the edge. The slot whose age equals `flush_age` is kept. In a flush cycle no insertion takes place and `iss_valid` is 0.
- R9: A tag on a bus whose `wb_valid` bit is 0 wakes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insertion request |
| ins_ready | output | 1 | A free slot exists |
| ins_src0_tag | input | TAG_W | First source register tag |
| ins_src0_rdy | input | 1 | First source already available |
| ins_src1_tag | input | TAG_W | Second source register tag |
| ins_src1_rdy | input | 1 | Second source already available (tie to 1 if unused) |
| ins_dst_tag | input | TAG_W | Destination register tag |
| ins_age | input | AGE_W | Program-order sequence number |
| wb_valid | input | NWB | Result bus valid bits |
| wb_tag | input | NWB x TAG_W | Result bus destination tags |
| flush_valid | input | 1 | Remove slots younger than the bound |
| flush_age | input | AGE_W | Flush age bound (kept) |
| iss_valid | output | 1 | A slot is granted this cycle |
| iss_src0_tag | output | TAG_W | Granted first source tag |
| iss_src1_tag | output | TAG_W | Granted second source tag |
| iss_dst_tag | output | TAG_W | Granted destination tag |
| iss_age | output | AGE_W | Granted age |

## Verification
The queue is filled completely with slots that wait on one shared tag, in a scrambled age order. One broadcast then wakes them all, and the drain order must come out strictly by age. This sweep runs once per result bus and once with ages that cross the counter wrap. The full state is also used to confirm that an extra insertion is dropped. Single-slot patterns tell apart a wake on either source, a tag on a bus whose valid bit is low, and a tag broadcast in the insertion cycle. Flush patterns with a bound inside the live range, including one that crosses the wrap, show which ages survive. They also show that an insertion offered during the flush is discarded.

// File: rtl/iq_pkg.sv
package iq_pkg;

    localparam int IQ_DEPTH   = 16;
    localparam int IQ_TAG_W   = 6;
    localparam int IQ_AGE_W   = 6;
    localparam int IQ_NWB     = 3;
    localparam int AGE_MAX_W  = 16;

    // a is older than b when the wrapped difference a-b is negative in w bits
    function automatic logic age_is_older(input logic [AGE_MAX_W-1:0] a,
                                          input logic [AGE_MAX_W-1:0] b,
                                          input int unsigned w);
        logic [AGE_MAX_W-1:0] d;
        d = a - b;
        return d[w-1];
    endfunction

endpackage

// File: rtl/iq_wakeup.sv
module iq_wakeup #(
    parameter int TAG_W = iq_pkg::IQ_TAG_W,
    parameter int NWB   = iq_pkg::IQ_NWB
) (
    input  logic [TAG_W-1:0]          src_tag,
    input  logic [NWB-1:0]            wb_valid,
    input  logic [NWB-1:0][TAG_W-1:0] wb_tag,
    output logic                      hit
);
    logic [NWB-1:0] match;

    for (genvar k = 0; k < NWB; k++) begin : g_port
        assign match[k] = wb_valid[k] && (wb_tag[k] == src_tag);
    end

    assign hit = |match;
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
    parameter int DEPTH = iq_pkg::IQ_DEPTH,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] occupied,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!occupied[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/iq_select.sv
module iq_select #(
    parameter int DEPTH = iq_pkg::IQ_DEPTH,
    parameter int AGE_W = iq_pkg::IQ_AGE_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [DEPTH-1:0]              req,
    input  logic [DEPTH-1:0][AGE_W-1:0]   ages,
    output logic [DEPTH-1:0]              grant,
    output logic                          gnt_valid,
    output logic [IDX_W-1:0]              gnt_idx
);
    import iq_pkg::*;

    logic [DEPTH-1:0] win;

    // a requester wins when no other requester is older (ties go to lower index)
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            win[i] = req[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && req[j]) begin
                    if (age_is_older(AGE_MAX_W'(ages[j]), AGE_MAX_W'(ages[i]), AGE_W))
                        win[i] = 1'b0;
                    else if (ages[j] == ages[i] && j < i)
                        win[i] = 1'b0;
                end
            end
        end
    end

    always_comb begin
        grant     = '0;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (win[i]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'(i);
            end
        end
        if (gnt_valid) grant[gnt_idx] = 1'b1;
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_chk_i
        for (genvar gj = 0; gj < DEPTH; gj++) begin : g_chk_j
            if (gi != gj) begin : g_pair
                p_oldest_first_r6: assert property (@(posedge clk) disable iff (rst)
                    (grant[gi] && req[gj]) |->
                        !age_is_older(AGE_MAX_W'(ages[gj]), AGE_MAX_W'(ages[gi]), AGE_W));
            end
        end
    end
endmodule

// File: rtl/iq_dataflow.sv
module iq_dataflow #(
    parameter int DEPTH = iq_pkg::IQ_DEPTH,
    parameter int TAG_W = iq_pkg::IQ_TAG_W,
    parameter int AGE_W = iq_pkg::IQ_AGE_W,
    parameter int NWB   = iq_pkg::IQ_NWB
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ins_valid,
    output logic                          ins_ready,
    input  logic [TAG_W-1:0]              ins_src0_tag,
    input  logic                          ins_src0_rdy,
    input  logic [TAG_W-1:0]              ins_src1_tag,
    input  logic                          ins_src1_rdy,
    input  logic [TAG_W-1:0]              ins_dst_tag,
    input  logic [AGE_W-1:0]              ins_age,
    input  logic [NWB-1:0]                wb_valid,
    input  logic [NWB-1:0][TAG_W-1:0]     wb_tag,
    input  logic                          flush_valid,
    input  logic [AGE_W-1:0]              flush_age,
    output logic                          iss_valid,
    output logic [TAG_W-1:0]              iss_src0_tag,
    output logic [TAG_W-1:0]              iss_src1_tag,
    output logic [TAG_W-1:0]              iss_dst_tag,
    output logic [AGE_W-1:0]              iss_age
);
    import iq_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [TAG_W-1:0] src0;
        logic [TAG_W-1:0] src1;
        logic [TAG_W-1:0] dst;
        logic [AGE_W-1:0] age;
    } slot_t;

    slot_t                        slot_q [DEPTH];
    logic [DEPTH-1:0]             valid_q, rdy0_q, rdy1_q;
    logic [DEPTH-1:0]             hit0, hit1, kill, req, grant;
    logic [DEPTH-1:0][AGE_W-1:0]  age_vec;
    logic                         ins_hit0, ins_hit1, alloc_found, gnt_valid, do_ins;
    logic [IDX_W-1:0]             alloc_idx, gnt_idx;

    // ---- wakeup CAM: per slot, per source ----
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        iq_wakeup #(.TAG_W(TAG_W), .NWB(NWB)) u_wk0 (
            .src_tag(slot_q[i].src0), .wb_valid(wb_valid), .wb_tag(wb_tag), .hit(hit0[i]));
        iq_wakeup #(.TAG_W(TAG_W), .NWB(NWB)) u_wk1 (
            .src_tag(slot_q[i].src1), .wb_valid(wb_valid), .wb_tag(wb_tag), .hit(hit1[i]));

        assign age_vec[i] = slot_q[i].age;
        assign req[i]     = valid_q[i] && rdy0_q[i] && rdy1_q[i];
        assign kill[i]    = flush_valid && valid_q[i] &&
                            age_is_older(AGE_MAX_W'(flush_age), AGE_MAX_W'(slot_q[i].age), AGE_W);
    end

    // same-cycle wakeup for the incoming instruction
    iq_wakeup #(.TAG_W(TAG_W), .NWB(NWB)) u_wk_in0 (
        .src_tag(ins_src0_tag), .wb_valid(wb_valid), .wb_tag(wb_tag), .hit(ins_hit0));
    iq_wakeup #(.TAG_W(TAG_W), .NWB(NWB)) u_wk_in1 (
        .src_tag(ins_src1_tag), .wb_valid(wb_valid), .wb_tag(wb_tag), .hit(ins_hit1));

    // ---- allocation ----
    iq_alloc #(.DEPTH(DEPTH)) u_alloc (
        .occupied(valid_q), .found(alloc_found), .idx(alloc_idx));

    assign ins_ready = alloc_found;
    assign do_ins    = ins_valid && alloc_found && !flush_valid;

    // ---- select ----
    iq_select #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_sel (
        .clk(clk), .rst(rst), .req(req), .ages(age_vec),
        .grant(grant), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx));

    assign iss_valid = gnt_valid && !flush_valid;

    always_comb begin
        iss_src0_tag = slot_q[gnt_idx].src0;
        iss_src1_tag = slot_q[gnt_idx].src1;
        iss_dst_tag  = slot_q[gnt_idx].dst;
        iss_age      = slot_q[gnt_idx].age;
    end

    // ---- slot state ----
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            rdy0_q  <= '0;
            rdy1_q  <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (kill[i] || (iss_valid && grant[i])) begin
                    valid_q[i] <= 1'b0;
                end else if (do_ins && alloc_idx == IDX_W'(i)) begin
                    valid_q[i]     <= 1'b1;
                    slot_q[i].src0 <= ins_src0_tag;
                    slot_q[i].src1 <= ins_src1_tag;
                    slot_q[i].dst  <= ins_dst_tag;
                    slot_q[i].age  <= ins_age;
                    rdy0_q[i]      <= ins_src0_rdy || ins_hit0;
                    rdy1_q[i]      <= ins_src1_rdy || ins_hit1;
                end else if (valid_q[i]) begin
                    rdy0_q[i] <= rdy0_q[i] || hit0[i];
                    rdy1_q[i] <= rdy1_q[i] || hit1[i];
                end
            end
        end
    end

    // ---- assertions ----
    p_grant_ready_r5: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (|(grant & valid_q & rdy0_q & rdy1_q)));

    p_grant_frees_r7: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> !valid_q[$past(gnt_idx)]);

    p_full_no_growth_r2: assert property (@(posedge clk) disable iff (rst)
        (&valid_q) |=> ($countones(valid_q) <= $past($countones(valid_q))));

    for (genvar i = 0; i < DEPTH; i++) begin : g_chk
        p_ready_sticky_r3: assert property (@(posedge clk) disable iff (rst)
            (valid_q[i] && rdy0_q[i] && rdy1_q[i] && !kill[i] && !(iss_valid && grant[i]))
                |=> (rdy0_q[i] && rdy1_q[i]));
        p_flush_removes_r8: assert property (@(posedge clk) disable iff (rst)
            kill[i] |=> !valid_q[i]);
    end
endmodule

// File: tb/iq_dataflow_test.sv
`timescale 1ns/1ps
module iq_dataflow_test;
    localparam int TAG_W = 6;
    localparam int AGE_W = 6;
    localparam int NWB   = 3;

    logic clk = 1'b0;
    logic rst;
    logic ins_valid, ins_ready, ins_src0_rdy, ins_src1_rdy;
    logic [TAG_W-1:0] ins_src0_tag, ins_src1_tag, ins_dst_tag;
    logic [AGE_W-1:0] ins_age;
    logic [NWB-1:0] wb_valid;
    logic [NWB-1:0][TAG_W-1:0] wb_tag;
    logic flush_valid;
    logic [AGE_W-1:0] flush_age;
    logic iss_valid;
    logic [TAG_W-1:0] iss_src0_tag, iss_src1_tag, iss_dst_tag;
    logic [AGE_W-1:0] iss_age;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    iq_dataflow uut (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_src0_tag(ins_src0_tag), .ins_src0_rdy(ins_src0_rdy),
        .ins_src1_tag(ins_src1_tag), .ins_src1_rdy(ins_src1_rdy),
        .ins_dst_tag(ins_dst_tag), .ins_age(ins_age),
        .wb_valid(wb_valid), .wb_tag(wb_tag),
        .flush_valid(flush_valid), .flush_age(flush_age),
        .iss_valid(iss_valid), .iss_src0_tag(iss_src0_tag), .iss_src1_tag(iss_src1_tag),
        .iss_dst_tag(iss_dst_tag), .iss_age(iss_age));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        ins_valid = 0; ins_src0_tag = 0; ins_src0_rdy = 0; ins_src1_tag = 0; ins_src1_rdy = 0;
        ins_dst_tag = 0; ins_age = 0; wb_valid = 0; wb_tag = '0; flush_valid = 0; flush_age = 0;
    endtask

    // start a cycle: wait for falling edge and clear inputs
    task automatic cyc();
        @(negedge clk);
        idle();
    endtask

    task automatic put(input int s0, input bit r0, input int s1, input bit r1,
                       input int dst, input int age);
        ins_valid = 1; ins_src0_tag = TAG_W'(s0); ins_src0_rdy = r0;
        ins_src1_tag = TAG_W'(s1); ins_src1_rdy = r1;
        ins_dst_tag = TAG_W'(dst); ins_age = AGE_W'(age);
    endtask

    task automatic expect_issue(input string req, input int dst, input int age);
        chk(iss_valid === 1'b1, req, int'(iss_valid), 1);
        chk(iss_dst_tag == TAG_W'(dst), req, int'(iss_dst_tag), dst);
        chk(iss_age == AGE_W'(age), req, int'(iss_age), age);
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: empty after reset
        chk(ins_ready === 1'b1, "R1 ins_ready", int'(ins_ready), 1);
        chk(iss_valid === 1'b0, "R1 iss_valid", int'(iss_valid), 0);

        // Fill 16 slots in scrambled age order, wake all with one tag, drain by age.
        for (int pass = 0; pass < 3; pass++) begin
            int base;
            base = (pass == 0) ? 0 : (pass == 1) ? 56 : 30;
            for (int k = 0; k < 16; k++) begin
                cyc();
                put(40, 0, 1, 1, k, (base + (k * 7) % 16) % 64);
                #1;
                chk(iss_valid === 1'b0, "R5 pending src", int'(iss_valid), 0);
            end
            cyc();
            #1;
            chk(ins_ready === 1'b0, "R2 full", int'(ins_ready), 0);
            // refused insertion while full
            cyc();
            put(1, 1, 1, 1, 63, (base + 20) % 64);
            #1;
            chk(ins_ready === 1'b0, "R2 full refuse", int'(ins_ready), 0);
            cyc();
            wb_valid[pass] = 1; wb_tag[pass] = 6'd40;
            #1;
            chk(iss_valid === 1'b0, "R3 wake not yet visible", int'(iss_valid), 0);
            for (int n = 0; n < 16; n++) begin
                cyc();
                #1;
                // R6: oldest first; dst of age base+n is (n*7)%16 since 7*7=1 mod 16
                expect_issue("R6 R7 drain order", (n * 7) % 16, (base + n) % 64);
            end
            cyc();
            #1;
            chk(iss_valid === 1'b0, "R2 dropped insert never issues", int'(iss_valid), 0);
            chk(ins_ready === 1'b1, "R7 slots freed", int'(ins_ready), 1);
        end

        // Per bus: two pending sources, invalid-bus tag ignored, wake via either source.
        for (int b = 0; b < 3; b++) begin
            cyc();
            put(10, 0, 11, 0, 20 + b, 5);
            cyc();
            wb_valid[b] = 0; wb_tag[b] = 6'd11;
            wb_valid[(b + 1) % 3] = 1; wb_tag[(b + 1) % 3] = 6'd10;
            #1;
            chk(iss_valid === 1'b0, "R5 both pending", int'(iss_valid), 0);
            cyc();
            #1;
            chk(iss_valid === 1'b0, "R9 R5 invalid bus ignored", int'(iss_valid), 0);
            cyc();
            wb_valid[b] = 1; wb_tag[b] = 6'd11;
            #1;
            chk(iss_valid === 1'b0, "R3 registered wake", int'(iss_valid), 0);
            cyc();
            #1;
            expect_issue("R3 wake both sources", 20 + b, 5);
            chk(iss_src0_tag == 6'd10, "R7 src0 tag out", int'(iss_src0_tag), 10);
            chk(iss_src1_tag == 6'd11, "R7 src1 tag out", int'(iss_src1_tag), 11);
            cyc();
            #1;
            chk(iss_valid === 1'b0, "R7 issued once", int'(iss_valid), 0);
        end

        // Same-cycle broadcast at insertion (R4).
        for (int b = 0; b < 3; b++) begin
            cyc();
            put(33, 0, 34, 0, 50 + b, 9);
            wb_valid[b] = 1; wb_tag[b] = 6'd33;
            wb_valid[(b + 2) % 3] = 1; wb_tag[(b + 2) % 3] = 6'd34;
            cyc();
            #1;
            expect_issue("R4 insert-cycle wake", 50 + b, 9);
            cyc();
            #1;
            chk(iss_valid === 1'b0, "R4 single issue", int'(iss_valid), 0);
        end

        // Flush with an age bound, including across the wrap (R8).
        for (int f = 0; f < 2; f++) begin
            int base;
            base = (f == 0) ? 10 : 60;
            for (int k = 0; k < 8; k++) begin
                cyc();
                put(40, 0, 1, 1, k, (base + k) % 64);
            end
            cyc();
            flush_valid = 1; flush_age = AGE_W'((base + 3) % 64);
            put(1, 1, 1, 1, 62, (base + 2) % 64);
            #1;
            chk(iss_valid === 1'b0, "R8 no issue in flush", int'(iss_valid), 0);
            cyc();
            wb_valid[0] = 1; wb_tag[0] = 6'd40;
            #1;
            chk(iss_valid === 1'b0, "R8 flush-cycle insert dropped", int'(iss_valid), 0);
            for (int n = 0; n < 4; n++) begin
                cyc();
                #1;
                expect_issue("R8 survivors", n, (base + n) % 64);
            end
            cyc();
            #1;
            chk(iss_valid === 1'b0, "R8 younger removed", int'(iss_valid), 0);
            chk(ins_ready === 1'b1, "R8 queue empty", int'(ins_ready), 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule